// File: doc/BRIEF.md
# Static-Prediction Resteer Controller

This block sits where the instruction queue first knows where each instruction begins and ends. For every control-transfer instruction it is told the transfer kind, whether the branch target array produced a matching entry, the instruction address and a sign-extended displacement. A target-array hit is left alone. So is any transfer that is not a conditional branch.

When a conditional branch misses in the target array, a backward-taken / forward-not-taken rule picks a direction. A forward or zero displacement keeps fetch on the fall-through path, and the block does nothing. A backward displacement raises a one-cycle clear. The clear discards every fetch block still upstream of the queue. Fetch is then held idle for a fixed bubble, after which a redirect to address plus displacement is issued.

A second qualifying branch that arrives while a bubble is active is dropped. A flush from the back end cancels any resteer in progress and outranks a new one. A saturating event counter records each clear and can be zeroed through a clear strobe.

Top module: `fe_static_resteer`

## Requirements
- R1: A valid conditional branch (kind code 1) that misses in the target array and has a negative displacement (bit ADDR_W-1 set) asserts clear_o for exactly one cycle. That cycle is the one after the cycle in which the branch was presented.
- R2: A valid conditional miss whose displacement is zero or positive causes no clear, no stall and no redirect.
- R3: A conditional branch whose target-array lookup hit causes no clear, no stall and no redirect, whatever its displacement.
- R4: Kind codes 0 (none), 2 (direct jump) and 3 (indirect) never cause a clear, and neither does a branch with br_valid_i low.
- R5: fetch_stall_o is high for exactly BUBBLE cycles (default 8), starting in the cycle in which clear_o is high.
- R6: redirect_valid_o pulses for one cycle, in the first cycle after the stall ends. In that cycle redirect_pc_o equals br_pc_i + br_disp_i modulo 2^ADDR_W.
- R7: A qualifying branch presented while fetch_stall_o is high is ignored. It gives no new clear, the pending target is kept and the counter is not incremented.
- R8: be_flush_i drives clear_o, fetch_stall_o and redirect_valid_o low in the next cycle and cancels a pending redirect. A qualifying branch presented in the same cycle as be_flush_i is not accepted.
- R9: evt_count_o increments by one for each clear and saturates at its all-ones value (CNT_W bits, default 16).
- R10: evt_clr_i zeroes evt_count_o in the next cycle and takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| br_valid_i | input | 1 | A control-transfer instruction is presented this cycle |
| br_kind_i | input | 2 | Transfer kind: 0 none, 1 conditional, 2 direct jump, 3 indirect |
| tgt_hit_i | input | 1 | Target-array lookup matched its tag |
| br_pc_i | input | ADDR_W | Instruction address |
| br_disp_i | input | ADDR_W | Sign-extended displacement |
| be_flush_i | input | 1 | Back-end pipeline flush |
| evt_clr_i | input | 1 | Zero the event counter |
| clear_o | output | 1 | One-cycle upstream fetch clear |
| fetch_stall_o | output | 1 | Fetch bubble active |
| redirect_valid_o | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc_o | output | ADDR_W | Redirect target |
| evt_count_o | output | CNT_W | Saturating count of clears |

## Verification
A qualifying branch that is sampled at edge 0 raises clear_o and fetch_stall_o in cycle 1. The stall stays high through cycle BUBBLE, and the redirect strobe and target appear in cycle BUBBLE+1. The counter shows its new value in cycle 1. A flush or counter clear takes effect one cycle after it is presented.

The bench drives inputs on falling edges and samples outputs on the following falling edges. It counts those edges from the stimulus, so each value is read in the exact cycle given above. The cycles around each result are also checked, to show that nothing comes early or stays late.

// File: rtl/fe_resteer_pkg.sv
package fe_resteer_pkg;
  typedef enum logic [1:0] {
    BR_NONE  = 2'd0,
    BR_COND  = 2'd1,
    BR_JUMP  = 2'd2,
    BR_INDIR = 2'd3
  } br_kind_e;
endpackage

// File: rtl/fe_static_dir.sv
module fe_static_dir #(
  parameter int ADDR_W = 32
) (
  input  logic                     valid_i,
  input  fe_resteer_pkg::br_kind_e kind_i,
  input  logic                     tgt_hit_i,
  input  logic [ADDR_W-1:0]        disp_i,
  output logic                     force_taken_o
);
  import fe_resteer_pkg::*;

  logic is_cond_miss;
  logic backward;

  assign is_cond_miss  = valid_i && (kind_i == BR_COND) && !tgt_hit_i;
  // backward taken, forward not taken
  assign backward      = disp_i[ADDR_W-1];
  assign force_taken_o = is_cond_miss && backward;
endmodule

// File: rtl/fe_bubble_timer.sv
module fe_bubble_timer #(
  parameter int ADDR_W = 32,
  parameter int BUBBLE = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              kill_i,
  input  logic [ADDR_W-1:0] tgt_i,
  output logic              accept_o,
  output logic              clear_o,
  output logic              stall_o,
  output logic              redir_o,
  output logic [ADDR_W-1:0] redir_pc_o
);
  localparam int CW = $clog2(BUBBLE + 1);

  logic [CW-1:0]     bub_q;
  logic              clr_q;
  logic              red_q;
  logic [ADDR_W-1:0] tgt_q;
  logic              busy;

  assign busy     = (bub_q != '0);
  assign accept_o = start_i && !busy && !kill_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bub_q <= '0;
      clr_q <= 1'b0;
      red_q <= 1'b0;
      tgt_q <= '0;
    end else if (kill_i) begin
      bub_q <= '0;
      clr_q <= 1'b0;
      red_q <= 1'b0;
    end else begin
      clr_q <= accept_o;
      red_q <= (bub_q == CW'(1));
      if (accept_o) begin
        bub_q <= CW'(BUBBLE);
        tgt_q <= tgt_i;
      end else if (busy) begin
        bub_q <= bub_q - CW'(1);
      end
    end
  end

  assign clear_o    = clr_q;
  assign stall_o    = busy;
  assign redir_o    = red_q;
  assign redir_pc_o = tgt_q;

  AST_CLEAR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |=> !clr_q); // R1
  AST_STALL_WITH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |-> busy); // R5
  AST_REDIR_AFTER_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    red_q |-> (!busy && $past(busy))); // R6
  AST_NO_START_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_i) |=> !clr_q); // R7
  AST_KILL_QUIETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> (!clr_q && !red_q && !busy)); // R8
endmodule

// File: rtl/fe_event_ctr.sv
module fe_event_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clr_i)                       cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX)   cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q >= $past(cnt_q))); // R9
  AST_CNT_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/fe_static_resteer.sv
module fe_static_resteer #(
  parameter int ADDR_W = 32,
  parameter int BUBBLE = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              br_valid_i,
  input  logic [1:0]        br_kind_i,
  input  logic              tgt_hit_i,
  input  logic [ADDR_W-1:0] br_pc_i,
  input  logic [ADDR_W-1:0] br_disp_i,
  input  logic              be_flush_i,
  input  logic              evt_clr_i,
  output logic              clear_o,
  output logic              fetch_stall_o,
  output logic              redirect_valid_o,
  output logic [ADDR_W-1:0] redirect_pc_o,
  output logic [CNT_W-1:0]  evt_count_o
);
  import fe_resteer_pkg::*;

  logic              force_taken;
  logic              accept;
  logic [ADDR_W-1:0] tgt_calc;

  assign tgt_calc = br_pc_i + br_disp_i;

  fe_static_dir #(.ADDR_W(ADDR_W)) i_dir (
    .valid_i       (br_valid_i),
    .kind_i        (br_kind_e'(br_kind_i)),
    .tgt_hit_i     (tgt_hit_i),
    .disp_i        (br_disp_i),
    .force_taken_o (force_taken)
  );

  fe_bubble_timer #(.ADDR_W(ADDR_W), .BUBBLE(BUBBLE)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (force_taken),
    .kill_i     (be_flush_i),
    .tgt_i      (tgt_calc),
    .accept_o   (accept),
    .clear_o    (clear_o),
    .stall_o    (fetch_stall_o),
    .redir_o    (redirect_valid_o),
    .redir_pc_o (redirect_pc_o)
  );

  fe_event_ctr #(.CNT_W(CNT_W)) i_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (accept),
    .clr_i  (evt_clr_i),
    .cnt_o  (evt_count_o)
  );

  AST_CLEAR_NEEDS_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_valid_i && (tgt_hit_i || br_kind_i != 2'd1)) && !fetch_stall_o |=> !clear_o); // R3
endmodule

// File: tb/test_fe_static_resteer.sv
module test_fe_static_resteer;
  localparam int AW  = 32;
  localparam int BUB = 8;
  localparam int CW  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          br_valid = 1'b0;
  logic [1:0]    br_kind = 2'd0;
  logic          tgt_hit = 1'b0;
  logic [AW-1:0] br_pc = '0;
  logic [AW-1:0] br_disp = '0;
  logic          be_flush = 1'b0;
  logic          evt_clr = 1'b0;
  logic          clear_w;
  logic          stall_w;
  logic          redir_w;
  logic [AW-1:0] redir_pc_w;
  logic [CW-1:0] cnt_w;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;

  always #5 clk = ~clk;

  fe_static_resteer #(.ADDR_W(AW), .BUBBLE(BUB), .CNT_W(CW)) i_fe_static_resteer (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .br_valid_i       (br_valid),
    .br_kind_i        (br_kind),
    .tgt_hit_i        (tgt_hit),
    .br_pc_i          (br_pc),
    .br_disp_i        (br_disp),
    .be_flush_i       (be_flush),
    .evt_clr_i        (evt_clr),
    .clear_o          (clear_w),
    .fetch_stall_o    (stall_w),
    .redirect_valid_o (redir_w),
    .redirect_pc_o    (redir_pc_w),
    .evt_count_o      (cnt_w)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bump();
    if (exp_cnt < (1 << CW) - 1) exp_cnt++;
  endtask

  // present for one cycle, return at negedge of cycle 1
  task automatic issue(input logic v, input logic [1:0] k, input logic hit,
                       input logic [AW-1:0] pc, input logic [AW-1:0] disp);
    @(negedge clk);
    br_valid = v; br_kind = k; tgt_hit = hit; br_pc = pc; br_disp = disp;
    @(negedge clk);
    br_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(clear_w == 1'b0, "R1 reset clear", 64'(clear_w), 0);
    chk(stall_w == 1'b0, "R5 reset stall", 64'(stall_w), 0);
    chk(redir_w == 1'b0, "R6 reset redirect", 64'(redir_w), 0);
    chk(cnt_w == '0, "R9 reset count", 64'(cnt_w), 0);
  endtask

  task automatic t_taken(input logic [AW-1:0] pc, input logic [AW-1:0] disp);
    logic [AW-1:0] tgt;
    tgt = pc + disp;
    issue(1'b1, 2'd1, 1'b0, pc, disp);
    bump();
    chk(clear_w == 1'b1, "R1 clear", 64'(clear_w), 1);
    chk(stall_w == 1'b1, "R5 stall start", 64'(stall_w), 1);
    chk(cnt_w == CW'(exp_cnt), "R9 count", 64'(cnt_w), 64'(exp_cnt));
    for (int i = 2; i <= BUB; i++) begin
      @(negedge clk);
      chk(stall_w && !clear_w, "R5 stall held / R1 single", {clear_w, stall_w}, 2'b01);
    end
    @(negedge clk);
    chk(!stall_w, "R5 stall end", 64'(stall_w), 0);
    chk(redir_w, "R6 redirect", 64'(redir_w), 1);
    chk(redir_pc_w == tgt, "R6 target", 64'(redir_pc_w), 64'(tgt));
    @(negedge clk);
    chk(!redir_w, "R6 single pulse", 64'(redir_w), 0);
  endtask

  task automatic t_quiet(input logic v, input logic [1:0] k, input logic hit,
                         input logic [AW-1:0] disp, input string req);
    issue(v, k, hit, 32'h0000_1000, disp);
    for (int i = 0; i < BUB + 2; i++) begin
      chk(!clear_w && !stall_w && !redir_w, req, {clear_w, stall_w, redir_w}, 0);
      @(negedge clk);
    end
    chk(cnt_w == CW'(exp_cnt), req, 64'(cnt_w), 64'(exp_cnt));
  endtask

  task automatic t_overlap();
    issue(1'b1, 2'd1, 1'b0, 32'h0000_4000, 32'hFFFF_FF00);
    bump();
    repeat (2) @(negedge clk);
    br_valid = 1'b1; br_kind = 2'd1; tgt_hit = 1'b0;
    br_pc = 32'h0000_8000; br_disp = 32'hFFFF_FFF0;
    @(negedge clk);
    br_valid = 1'b0;
    chk(!clear_w, "R7 no second clear", 64'(clear_w), 0);
    repeat (5) @(negedge clk);
    chk(redir_w, "R7 redirect once", 64'(redir_w), 1);
    chk(redir_pc_w == 32'h0000_3F00, "R7 first target kept", 64'(redir_pc_w), 64'h3F00);
    chk(cnt_w == CW'(exp_cnt), "R7 count once", 64'(cnt_w), 64'(exp_cnt));
    @(negedge clk);
  endtask

  task automatic t_flush();
    issue(1'b1, 2'd1, 1'b0, 32'h0000_2000, 32'hFFFF_FFFC);
    bump();
    @(negedge clk);
    be_flush = 1'b1;
    @(negedge clk);
    be_flush = 1'b0;
    chk(!stall_w && !clear_w, "R8 flush cancels", {clear_w, stall_w}, 0);
    for (int i = 0; i < BUB + 2; i++) begin
      @(negedge clk);
      chk(!redir_w && !stall_w, "R8 no redirect", {stall_w, redir_w}, 0);
    end
    @(negedge clk);
    br_valid = 1'b1; br_kind = 2'd1; tgt_hit = 1'b0; br_disp = 32'hFFFF_FF80;
    be_flush = 1'b1;
    @(negedge clk);
    br_valid = 1'b0; be_flush = 1'b0;
    chk(!clear_w && !stall_w, "R8 flush wins", {clear_w, stall_w}, 0);
    chk(cnt_w == CW'(exp_cnt), "R8 count unchanged", 64'(cnt_w), 64'(exp_cnt));
  endtask

  task automatic t_cnt_clear();
    @(negedge clk);
    evt_clr = 1'b1;
    @(negedge clk);
    evt_clr = 1'b0;
    exp_cnt = 0;
    chk(cnt_w == '0, "R10 clear", 64'(cnt_w), 0);
    br_valid = 1'b1; br_kind = 2'd1; tgt_hit = 1'b0; br_pc = 32'h100; br_disp = 32'hFFFF_FFF8;
    evt_clr = 1'b1;
    @(negedge clk);
    br_valid = 1'b0; evt_clr = 1'b0;
    chk(clear_w, "R1 clear alongside counter clear", 64'(clear_w), 1);
    chk(cnt_w == '0, "R10 clear beats increment", 64'(cnt_w), 0);
    repeat (BUB + 1) @(negedge clk);
  endtask

  task automatic t_saturate();
    for (int n = 0; n < (1 << CW) + 1; n++) t_taken(32'h0000_0800 + AW'(n * 64), 32'hFFFF_FFE0);
    chk(cnt_w == {CW{1'b1}}, "R9 saturate", 64'(cnt_w), 64'((1 << CW) - 1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_taken(32'h0000_1000, 32'hFFFF_FF00);
    t_taken(32'h0000_0010, 32'hFFFF_FFE0);            // R6 wrap to FFFFFFF0
    t_quiet(1'b1, 2'd1, 1'b0, 32'h0000_0040, "R2 forward");
    t_quiet(1'b1, 2'd1, 1'b0, 32'h0000_0000, "R2 zero");
    t_quiet(1'b1, 2'd1, 1'b1, 32'hFFFF_FF00, "R3 hit");
    t_quiet(1'b1, 2'd2, 1'b0, 32'hFFFF_FF00, "R4 jump");
    t_quiet(1'b1, 2'd3, 1'b0, 32'hFFFF_FF00, "R4 indirect");
    t_quiet(1'b1, 2'd0, 1'b0, 32'hFFFF_FF00, "R4 none");
    t_quiet(1'b0, 2'd1, 1'b0, 32'hFFFF_FF00, "R4 not valid");
    t_overlap();
    t_flush();
    t_cnt_clear();
    t_saturate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule